// File: doc/BRIEF.md
# Dual-Mode Four-Channel Host Bus Decoder

This block sits between an asynchronous host bus and four identical register-mapped serial channels. It accepts one of two host bus conventions, picked by a mode pin. In the split-strobe convention the host has one active-low chip select per channel and separate active-low read and write strobes. In the shared-strobe convention the host drives a single chip select, two channel address bits and one read/write line: a falling edge of that line writes and a rising edge reads.

All host inputs cross into the system clock through two-flop synchronizers. Each qualifying strobe edge becomes a single-cycle write or read pulse, together with a registered one-hot channel select, a three-bit register index and the write data. A data-out path with an enable returns the addressed register of the addressed channel. The channel interrupts leave the block either as four separate active-high outputs (split-strobe) or as one shared pull-low request (shared-strobe). The reset pin changes polarity with the mode. The channel register files are small stubs: eight byte registers per channel.

Top module: `qbus_front`

## Requirements
- R1: `mode_pin` high selects the split-strobe convention and low selects the shared-strobe convention. A board pull-up is expected to hold the pin high when it is undriven.
- R2: In split-strobe mode, a single low bit `cs_n[i]` makes `ch_sel` equal to the one-hot value with bit i set. All `cs_n` bits high gives `ch_sel` = 0.
- R3: In split-strobe mode, two or more low `cs_n` bits give `ch_sel` = 0. No write or read pulse is issued, and the registers keep their contents.
- R4: In shared-strobe mode, `cs_n[0]` low with `ch_addr` = k (0..3) selects channel k (`ch_sel` bit k). `cs_n[0]` high selects nothing. `cs_n[3:1]` are ignored.
- R5: In shared-strobe mode, a falling edge of `wr_n` gives one write pulse and a rising edge gives one read pulse. `rd_n` has no effect.
- R6: In split-strobe mode, a falling edge of `wr_n` gives one write pulse and a falling edge of `rd_n` gives one read pulse. Each pulse lasts exactly one clock, follows the pin edge by three clocks, and occurs once per edge.
- R7: `reg_addr` carries `addr[2:0]`. A write stores `wr_data` into register `reg_addr` of the selected channel. A later read of that channel and index returns the stored byte on `dout`.
- R8: `dout_oe` is 1 only while a read is active on a selected channel, and `dout` is 0 whenever `dout_oe` is 0. A read is active when `rd_n` is low in split-strobe mode, or when `wr_n` is high in shared-strobe mode.
- R9: In split-strobe mode, `int_out` follows `ch_int` and `irq_pull_low` is 0. In shared-strobe mode, `int_out` is 0 and `irq_pull_low` is the OR of `ch_int`.
- R10: `rst_pin` is active high in split-strobe mode and active low in shared-strobe mode. Reset clears every output and every channel register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mode_pin | input | 1 | 1 = split strobes, 0 = shared read/write line |
| rst_pin | input | 1 | Reset pin; polarity follows the mode |
| cs_n | input | 4 | Per-channel selects (split); bit 0 is the only select (shared) |
| ch_addr | input | 2 | Channel number, used in shared mode only |
| rd_n | input | 1 | Read strobe, used in split mode only |
| wr_n | input | 1 | Write strobe (split) or read/write line (shared) |
| addr | input | 3 | Register index inside the channel |
| din | input | 8 | Host write data |
| ch_int | input | 4 | Interrupt request from each channel |
| ch_sel | output | 4 | Registered one-hot channel select |
| reg_addr | output | 3 | Registered register index |
| wr_data | output | 8 | Registered write data |
| wr_pulse | output | 1 | One-cycle write strobe |
| rd_pulse | output | 1 | One-cycle read strobe |
| dout | output | 8 | Read data toward the host |
| dout_oe | output | 1 | Drive enable for the host data bus |
| int_out | output | 4 | Per-channel active-high interrupts (split mode) |
| irq_pull_low | output | 1 | 1 = pull the shared request line low (shared mode) |

## Verification
The bench uses the default parameters: two channel address bits (four channels), three register index bits and an 8-bit data path. With these values, every chip-select pattern can be tried, including the double-select error, and every channel can be written and read back at the lowest and highest register index. Both bus conventions are run, each entered through its own reset polarity.

// File: rtl/qbus_pkg.sv
package qbus_pkg;

    localparam int DEF_CH_AW = 2;
    localparam int DEF_AW    = 3;
    localparam int DEF_DW    = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    function automatic int unsigned count_ones(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += 32'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/qbus_sync.sv
module qbus_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        stage1 <= d;
        stage2 <= stage1;
    end

    assign q = stage2;
endmodule

// File: rtl/qbus_chan_stub.sv
module qbus_chan_stub #(
    parameter int AW = 3,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/qbus_decode.sv
module qbus_decode #(
    parameter int CH_AW = 2,
    parameter int AW    = 3,
    parameter int DW    = 8,
    localparam int NCH  = 1 << CH_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sep,
    input  logic [NCH-1:0]    cs_n_s,
    input  logic [CH_AW-1:0]  ch_addr_s,
    input  logic              rd_n_s,
    input  logic              wr_n_s,
    input  logic [AW-1:0]     addr_s,
    input  logic [DW-1:0]     din_s,
    input  logic [NCH*DW-1:0] rdata_flat,
    output logic [NCH-1:0]    sel_q,
    output logic [AW-1:0]     addr_q,
    output logic [DW-1:0]     wdata_q,
    output logic              wr_pulse_q,
    output logic              rd_pulse_q,
    output logic              oe_q,
    output logic [DW-1:0]     dout_q
);
    import qbus_pkg::*;

    logic [NCH-1:0] cs_low, sel_sep, sel_cmb, sel_now;
    int unsigned    n_low;
    logic           wr_prev, rd_prev;
    logic           any_sel, rd_active;
    acc_e           ev;
    logic [DW-1:0]  mux_data;

    // channel selection in both conventions
    always_comb begin
        cs_low  = ~cs_n_s;
        n_low   = count_ones(32'(cs_low));
        sel_sep = (n_low == 1) ? cs_low : '0;
        sel_cmb = '0;
        if (!cs_n_s[0]) begin
            sel_cmb[ch_addr_s] = 1'b1;
        end
        sel_now = mode_sep ? sel_sep : sel_cmb;
        any_sel = |sel_now;
    end

    // strobe edge classification
    always_comb begin
        ev = ACC_IDLE;
        if (wr_prev && !wr_n_s) begin
            ev = ACC_WRITE;
        end else if (mode_sep && rd_prev && !rd_n_s) begin
            ev = ACC_READ;
        end else if (!mode_sep && !wr_prev && wr_n_s) begin
            ev = ACC_READ;
        end
        rd_active = mode_sep ? !rd_n_s : wr_n_s;
    end

    always_comb begin
        mux_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_now[i]) begin
                mux_data = mux_data | rdata_flat[i*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev    <= 1'b1;
            rd_prev    <= 1'b1;
            sel_q      <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            wr_pulse_q <= 1'b0;
            rd_pulse_q <= 1'b0;
            oe_q       <= 1'b0;
            dout_q     <= '0;
        end else begin
            wr_prev    <= wr_n_s;
            rd_prev    <= rd_n_s;
            sel_q      <= sel_now;
            addr_q     <= addr_s;
            wdata_q    <= din_s;
            wr_pulse_q <= any_sel && (ev == ACC_WRITE);
            rd_pulse_q <= any_sel && (ev == ACC_READ);
            oe_q       <= any_sel && rd_active;
            dout_q     <= (any_sel && rd_active) ? mux_data : '0;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_q)); // R2
    AST_ACCESS_HAS_SEL: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse_q || rd_pulse_q) |-> (sel_q != '0)); // R3
    AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse_q |=> !wr_pulse_q); // R6
    AST_RD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_pulse_q |=> !rd_pulse_q); // R6
    AST_OE_HAS_SEL: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (sel_q != '0)); // R8
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !oe_q |-> (dout_q == '0)); // R8
endmodule

// File: rtl/qbus_front.sv
module qbus_front #(
    parameter int CH_AW = qbus_pkg::DEF_CH_AW,
    parameter int AW    = qbus_pkg::DEF_AW,
    parameter int DW    = qbus_pkg::DEF_DW,
    localparam int NCH  = 1 << CH_AW
) (
    input  logic             clk,
    input  logic             mode_pin,
    input  logic             rst_pin,
    input  logic [NCH-1:0]   cs_n,
    input  logic [CH_AW-1:0] ch_addr,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    input  logic [NCH-1:0]   ch_int,
    output logic [NCH-1:0]   ch_sel,
    output logic [AW-1:0]    reg_addr,
    output logic [DW-1:0]    wr_data,
    output logic             wr_pulse,
    output logic             rd_pulse,
    output logic [DW-1:0]    dout,
    output logic             dout_oe,
    output logic [NCH-1:0]   int_out,
    output logic             irq_pull_low
);
    localparam int SW = 1 + NCH + CH_AW + 2 + AW + DW;

    logic [SW-1:0]     raw_v, sync_v;
    logic              mode_s, rd_n_s, wr_n_s;
    logic [NCH-1:0]    cs_n_s;
    logic [CH_AW-1:0]  ch_addr_s;
    logic [AW-1:0]     addr_s;
    logic [DW-1:0]     din_s;
    logic [1:0]        rst_pipe;
    logic              rst_i;
    logic [NCH*DW-1:0] rdata_flat;
    logic [NCH-1:0]    int_q;
    logic              pull_q;

    // reset polarity follows the raw mode pin, then two flops
    always_ff @(posedge clk) begin
        rst_pipe <= {rst_pipe[0], mode_pin ? rst_pin : ~rst_pin};
    end
    assign rst_i = rst_pipe[1];

    assign raw_v = {mode_pin, cs_n, ch_addr, rd_n, wr_n, addr, din};

    qbus_sync #(.W(SW)) u_sync (.clk(clk), .d(raw_v), .q(sync_v));

    assign {mode_s, cs_n_s, ch_addr_s, rd_n_s, wr_n_s, addr_s, din_s} = sync_v;

    qbus_decode #(.CH_AW(CH_AW), .AW(AW), .DW(DW)) u_dec (
        .clk(clk), .rst(rst_i), .mode_sep(mode_s),
        .cs_n_s(cs_n_s), .ch_addr_s(ch_addr_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
        .addr_s(addr_s), .din_s(din_s), .rdata_flat(rdata_flat),
        .sel_q(ch_sel), .addr_q(reg_addr), .wdata_q(wr_data),
        .wr_pulse_q(wr_pulse), .rd_pulse_q(rd_pulse),
        .oe_q(dout_oe), .dout_q(dout)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        qbus_chan_stub #(.AW(AW), .DW(DW)) u_ch (
            .clk(clk), .rst(rst_i),
            .we(wr_pulse && ch_sel[g]),
            .waddr(reg_addr), .wdata(wr_data),
            .raddr(addr_s), .rdata(rdata_flat[g*DW +: DW])
        );
    end

    // interrupt topology per mode
    always_ff @(posedge clk) begin
        if (rst_i) begin
            int_q  <= '0;
            pull_q <= 1'b0;
        end else begin
            int_q  <= mode_s ? ch_int : '0;
            pull_q <= !mode_s && (|ch_int);
        end
    end

    assign int_out      = int_q;
    assign irq_pull_low = pull_q;

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst_i)
        !(pull_q && (int_q != '0))); // R9
endmodule

// File: tb/sim_qbus_front.sv
module sim_qbus_front;
    logic       clk = 1'b0;
    logic       mode_pin = 1'b1, rst_pin = 1'b1;
    logic [3:0] cs_n = 4'hF;
    logic [1:0] ch_addr = '0;
    logic       rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] din = '0;
    logic [3:0] ch_int = '0;
    logic [3:0] ch_sel, int_out;
    logic [2:0] reg_addr;
    logic [7:0] wr_data, dout;
    logic       wr_pulse, rd_pulse, dout_oe, irq_pull_low;

    always #4 clk = ~clk;

    qbus_front u0 (
        .clk(clk), .mode_pin(mode_pin), .rst_pin(rst_pin), .cs_n(cs_n),
        .ch_addr(ch_addr), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
        .ch_int(ch_int), .ch_sel(ch_sel), .reg_addr(reg_addr), .wr_data(wr_data),
        .wr_pulse(wr_pulse), .rd_pulse(rd_pulse), .dout(dout), .dout_oe(dout_oe),
        .int_out(int_out), .irq_pull_low(irq_pull_low)
    );

    typedef struct {
        logic       is_wr;
        logic [3:0] sel;
        logic [2:0] a;
        logic [7:0] d;
        string      req;
    } exp_t;

    exp_t       q[$];
    exp_t       e;
    logic [7:0] mem [4][8];
    int         checks = 0;
    int         errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int idx_of(input logic [3:0] oh);
        for (int i = 0; i < 4; i++) if (oh[i]) return i;
        return 0;
    endfunction

    task automatic clear_model();
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 8; a++) mem[c][a] = 8'h00;
    endtask

    // monitor: every pulse must match the next queued item
    always @(negedge clk) begin
        if (wr_pulse || rd_pulse) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3 R5 unexpected access", {30'd0, wr_pulse, rd_pulse}, 32'd0);
            end else begin
                e = q.pop_front();
                chk(wr_pulse == e.is_wr && rd_pulse == !e.is_wr, {e.req, " kind"},
                    {30'd0, wr_pulse, rd_pulse}, {30'd0, e.is_wr, !e.is_wr});
                chk(ch_sel == e.sel, {e.req, " sel"}, 32'(ch_sel), 32'(e.sel));
                chk(reg_addr == e.a, "R7 reg_addr", 32'(reg_addr), 32'(e.a));
                if (e.is_wr) chk(wr_data == e.d, "R7 wr_data", 32'(wr_data), 32'(e.d));
                else         chk(dout == e.d, "R7 read data", 32'(dout), 32'(e.d));
            end
        end
    end

    task automatic do_reset(input bit sep);
        mode_pin = sep; rst_pin = sep;
        cs_n = 4'hF; rd_n = 1'b1; wr_n = 1'b1; ch_int = '0;
        wait_n(4);
        chk(ch_sel == 0 && dout_oe == 0 && dout == 0, "R10 reset outputs",
            {ch_sel, dout_oe, dout}, 0);
        chk(!wr_pulse && !rd_pulse && int_out == 0 && !irq_pull_low, "R10 reset flags",
            {wr_pulse, rd_pulse, int_out, irq_pull_low}, 0);
        rst_pin = !sep;
        wait_n(4);
        clear_model();
        q.delete();
    endtask

    task automatic sep_write(input logic [3:0] csn, input logic [2:0] a, input logic [7:0] d);
        bit valid;
        valid = ($countones(~csn) == 1);
        addr = a; din = d; cs_n = csn;
        wait_n(4);
        chk(ch_sel == (valid ? ~csn : 4'h0), valid ? "R2 split select" : "R3 double select",
            32'(ch_sel), 32'(valid ? ~csn : 4'h0));
        if (valid) begin
            q.push_back('{1'b1, ~csn, a, d, "R6 split write"});
            mem[idx_of(~csn)][a] = d;
        end
        wr_n = 1'b0; wait_n(4);
        wr_n = 1'b1; wait_n(3);
        cs_n = 4'hF; wait_n(3);
    endtask

    task automatic sep_read(input logic [3:0] csn, input logic [2:0] a);
        logic [7:0] ex;
        cs_n = csn; addr = a;
        ex = mem[idx_of(~csn)][a];
        wait_n(3);
        q.push_back('{1'b0, ~csn, a, ex, "R6 split read"});
        rd_n = 1'b0; wait_n(5);
        chk(dout_oe == 1'b1, "R8 oe during read", 32'(dout_oe), 1);
        chk(dout == ex, "R7 split readback", 32'(dout), 32'(ex));
        rd_n = 1'b1; wait_n(4);
        chk(dout_oe == 1'b0 && dout == 0, "R8 bus released", {dout_oe, dout}, 0);
        cs_n = 4'hF; wait_n(3);
    endtask

    task automatic cmb_write(input logic [1:0] ch, input logic [2:0] a, input logic [7:0] d);
        cs_n = 4'hF; wr_n = 1'b1; ch_addr = ch; addr = a; din = d;
        wait_n(3);
        cs_n = 4'b0100;          // bit 0 low; upper bits are ignored here (R4)
        wait_n(4);
        chk(ch_sel == (4'b1 << ch), "R4 shared select", 32'(ch_sel), 32'(4'b1 << ch));
        q.push_back('{1'b1, 4'b1 << ch, a, d, "R5 shared write"});
        mem[ch][a] = d;
        wr_n = 1'b0; wait_n(4);
        cs_n = 4'hF; wait_n(3);
        wr_n = 1'b1; wait_n(3);
    endtask

    task automatic cmb_read(input logic [1:0] ch, input logic [2:0] a);
        logic [7:0] ex;
        ex = mem[ch][a];
        cs_n = 4'hF; wr_n = 1'b0; ch_addr = ch; addr = a;
        wait_n(3);
        cs_n = 4'b1010;
        wait_n(4);
        chk(dout_oe == 1'b0, "R8 no oe while line low", 32'(dout_oe), 0);
        q.push_back('{1'b0, 4'b1 << ch, a, ex, "R5 shared read"});
        wr_n = 1'b1; wait_n(5);
        chk(dout_oe == 1'b1, "R8 oe shared read", 32'(dout_oe), 1);
        chk(dout == ex, "R7 shared readback", 32'(dout), 32'(ex));
        cs_n = 4'hF; wait_n(4);
        chk(dout_oe == 1'b0, "R8 released on deselect", 32'(dout_oe), 0);
    endtask

    initial begin
        // R1: split-strobe convention with mode pin high
        do_reset(1'b1);
        sep_write(4'b1110, 3'd1, 8'h11);
        sep_write(4'b1101, 3'd2, 8'h22);
        sep_write(4'b1011, 3'd0, 8'h33);
        sep_write(4'b1011, 3'd7, 8'h3F);
        sep_write(4'b0111, 3'd4, 8'h44);
        sep_read(4'b1110, 3'd1);
        sep_read(4'b1101, 3'd2);
        sep_read(4'b1011, 3'd0);
        sep_read(4'b1011, 3'd7);
        sep_read(4'b0111, 3'd4);
        // R3: two selects low, write ignored, then read back unchanged
        sep_write(4'b1010, 3'd1, 8'hAA);
        sep_read(4'b1110, 3'd1);
        sep_read(4'b1011, 3'd1);
        // R9: separate interrupt outputs
        ch_int = 4'b1001; wait_n(3);
        chk(int_out == 4'b1001, "R9 split int", 32'(int_out), 32'h9);
        chk(irq_pull_low == 1'b0, "R9 split no shared irq", 32'(irq_pull_low), 0);
        ch_int = 4'b0000; wait_n(3);
        // R10: active-high reset pulse clears the registers
        sep_write(4'b1101, 3'd3, 8'h5A);
        rst_pin = 1'b1; wait_n(4);
        rst_pin = 1'b0; wait_n(4);
        clear_model();
        sep_read(4'b1101, 3'd3);

        // R1: shared-strobe convention with mode pin low
        do_reset(1'b0);
        cmb_write(2'd0, 3'd0, 8'hA0);
        cmb_write(2'd1, 3'd5, 8'hB5);
        cmb_write(2'd2, 3'd7, 8'hC7);
        cmb_write(2'd3, 3'd2, 8'hD2);
        cmb_read(2'd0, 3'd0);
        cmb_read(2'd1, 3'd5);
        cmb_read(2'd2, 3'd7);
        cmb_read(2'd3, 3'd2);
        // R4: select high, line toggles give nothing
        cs_n = 4'b0001; ch_addr = 2'd2; wait_n(4);
        chk(ch_sel == 0, "R4 no select with bit0 high", 32'(ch_sel), 0);
        wr_n = 1'b0; wait_n(4); wr_n = 1'b1; wait_n(4);
        cs_n = 4'hF; wait_n(3);
        // R5: read strobe ignored in shared mode
        wr_n = 1'b0; wait_n(3);
        cs_n = 4'b1110; ch_addr = 2'd1; addr = 3'd5; wait_n(4);
        rd_n = 1'b0; wait_n(5);
        chk(dout_oe == 1'b0 && dout == 0, "R5 rd_n ignored", {dout_oe, dout}, 0);
        rd_n = 1'b1; wait_n(4);
        cs_n = 4'hF; wait_n(3);
        wr_n = 1'b1; wait_n(3);
        // R9: shared pull-low request
        ch_int = 4'b0010; wait_n(3);
        chk(irq_pull_low == 1'b1, "R9 shared irq on", 32'(irq_pull_low), 1);
        chk(int_out == 4'b0000, "R9 split outputs quiet", 32'(int_out), 0);
        ch_int = 4'b0000; wait_n(3);
        chk(irq_pull_low == 1'b0, "R9 shared irq off", 32'(irq_pull_low), 0);
        // R10: rst_pin high is idle here; low resets
        cmb_write(2'd3, 3'd6, 8'hC3);
        wait_n(10);
        cmb_read(2'd3, 3'd6);
        rst_pin = 1'b0; wait_n(4);
        rst_pin = 1'b1; wait_n(4);
        clear_model();
        cmb_read(2'd3, 3'd6);
        cmb_read(2'd0, 3'd0);

        wait_n(10);
        chk(q.size() == 0, "R6 every queued access seen", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule